// File: doc/BRIEF.md
# Parallel NOR Flash Command Controller

This block is the device side of a parallel NOR flash command interface. It sits behind a simple synchronous bus. Each write cycle presents a word address and a data word. The low data byte is taken as a command byte or as the next step of a multi-write sequence. The block decodes read-array, read-status, identifier, query, word program, buffered program, block erase, suspend, resume, lock-bit and clear-status operations. A small word array stands in for the cells, and one lock bit is kept per block.

Two cycle counters take the place of the internal write and erase engine, so program, erase and lock work is busy for a number of clock cycles set by parameters. The erase counter and the program counter are separate. An erase can therefore be suspended, array reads and a program into another block can run, and the erase can then be resumed. A program can be suspended in the same way.

An 8-bit status word reports:
- readiness,
- the two suspend states,
- sticky error flags for a locked target, a missing program supply and a broken command sequence.

Top module: `nor_cmd_ctrl`

## Requirements
- R1: After reset the block is ready, reads return array words, every word reads 0xFFFF, no block is locked, and a status read returns 0x0080.
- R2: Command 0xFF selects array reads. Command 0x70 selects status reads, which return the status byte on data bits 7..0 with bits 15..8 at zero. Each read returns data exactly one clock edge after the edge that samples `rd_en`.
- R3: Program works as follows:
  - Command 0x40 or 0x10, followed by a write of address and data, starts a word program and selects status reads.
  - Status reads sampled on the PROG_CYC edges after the data write report busy, and the next one reports ready.
  - The word then holds its old value ANDed with the data.
- R4: Status bit 7 is 1 when ready and 0 when busy. While bit 7 is 0, status bits 6..0 read as 0.
- R5: Erase and sequence errors behave as follows:
  - Command 0x20 at a block address, then 0xD0, erases that block: all of its words read 0xFFFF once ERASE_CYC busy cycles have passed.
  - Any other second byte erases nothing and sets status bits 5 and 4.
  - A bad second byte after 0x60, or after the buffer confirm, also sets status bits 5 and 4.
- R6: While `vpen_ok` is 0, any program, buffered program, erase or lock attempt sets status bits 3 and 4. It changes no word and never makes the block busy.
- R7: Lock bits work as follows:
  - Command 0x60 then 0x01 sets the lock bit of the block addressed by the 0x60 write. Command 0x60 then 0xD0 clears all lock bits.
  - A program or buffered program into a locked block sets status bits 1 and 4 and changes nothing.
  - An erase of a locked block sets status bits 1 and 5 and changes nothing.
- R8: Error bits 5, 4, 3 and 1 stay set across all other commands until command 0x50 clears them.
- R9: Erase suspend and resume work as follows:
  - Command 0xB0 during an erase makes the engine halt. It halts at the first later edge where the remaining busy count is a multiple of SUSP_GRAIN. The remaining count starts at ERASE_CYC on the confirm edge and drops by one on each later edge.
  - Once halted, the block reports ready with status bit 6 set.
  - Command 0xD0 resumes the erase, which then completes.
- R10: While an erase is suspended, array reads and a word program to another block are accepted. Status bit 6 stays set through that program.
- R11: Command 0xB0 during a word program suspends it at the same kind of checkpoint, with status bit 2 set and the word not yet written. Command 0xD0 resumes the program, which then completes.
- R12: While busy, only 0x70 and 0xB0 are acted on. While any operation is suspended, 0x20 and 0x60 are ignored, and so is any program command while a program is suspended.
- R13: Command 0x90 selects identifier reads:
  - Offset 0 within a block returns the manufacturer code MAN_ID (default 0x89) on bits 7..0 with bits 15..8 at zero.
  - Offset 1 returns DEV_CODE.
  - Offset 2 returns that block's lock bit on bit 0.

  Command 0x98 selects query reads, in which word addresses 0x10, 0x11 and 0x12 return 0x0051, 0x0052 and 0x0059.
- R14: Buffered program works as follows:
  - Command 0xE8, then a count N-1, then N address and data writes, then 0xD0, programs all N words (AND) after PROG_CYC busy cycles.
  - A count above BUF_WORDS-1 sets status bits 5 and 4 and programs nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | One bus write cycle, sampled on the rising edge |
| wr_addr | input | AW | Word address of the write |
| wr_data | input | 16 | Write data; bits 7..0 carry command bytes |
| rd_en | input | 1 | One bus read cycle, sampled on the rising edge |
| rd_addr | input | AW | Word address of the read |
| rd_valid | output | 1 | Read data valid, one edge after `rd_en` |
| rd_data | output | 16 | Read data for the current read mode |
| vpen_ok | input | 1 | Program supply above lockout level |
| ready | output | 1 | Engine idle or halted (status bit 7) |

## Verification
Read data is due one edge after the edge that samples `rd_en`. The scoreboard therefore pops the expected word on the falling edge that follows. Program ready is due on the read sampled PROG_CYC+1 edges after the data write. The suspend halt is due on the first checkpoint edge of the remaining count. The bench issues writes on consecutive edges and places its status reads on those exact edges, with one read just before each transition and one just after it. Where exact timing does not matter, such as erase completion, the bench waits well past the due edge before reading.

// File: rtl/nor_cmd_ctrl.sv
module nor_cmd_ctrl #(
  parameter int AW         = 8,
  parameter int BLK_W      = 2,
  parameter int PROG_CYC   = 6,
  parameter int ERASE_CYC  = 12,
  parameter int SUSP_GRAIN = 4,
  parameter int BUF_WORDS  = 4,
  parameter logic [7:0] MAN_ID   = 8'h89,
  parameter logic [7:0] DEV_CODE = 8'h17
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [15:0]   wr_data,
  input  logic          rd_en,
  input  logic [AW-1:0] rd_addr,
  output logic          rd_valid,
  output logic [15:0]   rd_data,
  input  logic          vpen_ok,
  output logic          ready
);
  localparam int DEPTH = 1 << AW;
  localparam int NBLK  = 1 << BLK_W;
  localparam int OFF_W = AW - BLK_W;
  localparam int MAXC  = (ERASE_CYC > PROG_CYC) ? ERASE_CYC : PROG_CYC;
  localparam int CW    = $clog2(MAXC + 1);
  localparam int BW    = (BUF_WORDS > 1) ? $clog2(BUF_WORDS) : 1;

  typedef enum logic [1:0] {M_ARRAY, M_STATUS, M_IDENT, M_QUERY} mode_t;
  typedef enum logic [2:0] {S_IDLE, S_PDATA, S_ECONF, S_LCONF, S_BCNT, S_BDATA, S_BCONF} seq_t;
  typedef enum logic [1:0] {K_WORD, K_BUF, K_LSET, K_LCLR} kind_t;

  logic [15:0]     mem [DEPTH];
  logic [NBLK-1:0] lock;
  mode_t           mode;
  seq_t            seq;
  logic            err_e, err_p, err_v, err_l;
  logic [BLK_W-1:0] s_blk;

  logic            p_run, p_susp, p_req;
  logic [CW-1:0]   p_cnt;
  kind_t           p_kind;
  logic [AW-1:0]   p_addr;
  logic [15:0]     p_data;
  logic            e_run, e_susp, e_req;
  logic [CW-1:0]   e_cnt;
  logic [BLK_W-1:0] e_blk;

  logic [AW-1:0]   b_addr [BUF_WORDS];
  logic [15:0]     b_data [BUF_WORDS];
  logic [BW-1:0]   b_last, b_idx;

  wire p_act = p_run & ~p_susp;
  wire e_act = e_run & ~e_susp;
  assign ready = ~(p_act | e_act);

  wire p_done = p_act && p_cnt == CW'(1);
  wire e_done = e_act && e_cnt == CW'(1);
  wire p_halt = p_act && p_req && !p_done && (int'(p_cnt) % SUSP_GRAIN == 0);
  wire e_halt = e_act && e_req && !e_done && (int'(e_cnt) % SUSP_GRAIN == 0);

  wire [7:0]       cmd   = wr_data[7:0];
  wire [BLK_W-1:0] w_blk = wr_addr[AW-1 -: BLK_W];
  wire [BLK_W-1:0] r_blk = rd_addr[AW-1 -: BLK_W];
  wire [7:0] sr = ready ? {1'b1, e_susp, err_e, err_p, err_v, p_susp, err_l, 1'b0} : 8'h00;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_valid <= 1'b0;
      rd_data  <= '0;
    end else begin
      rd_valid <= rd_en;
      if (rd_en) begin
        case (mode)
          M_ARRAY:  rd_data <= mem[rd_addr];
          M_STATUS: rd_data <= {8'h00, sr};
          M_IDENT: begin
            if (rd_addr[OFF_W-1:0] == OFF_W'(0))      rd_data <= {8'h00, MAN_ID};
            else if (rd_addr[OFF_W-1:0] == OFF_W'(1)) rd_data <= {8'h00, DEV_CODE};
            else if (rd_addr[OFF_W-1:0] == OFF_W'(2)) rd_data <= {15'h0, lock[r_blk]};
            else                                      rd_data <= '0;
          end
          default: begin
            if (rd_addr == AW'(8'h10))      rd_data <= 16'h0051;
            else if (rd_addr == AW'(8'h11)) rd_data <= 16'h0052;
            else if (rd_addr == AW'(8'h12)) rd_data <= 16'h0059;
            else                            rd_data <= '0;
          end
        endcase
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int j = 0; j < DEPTH; j++) mem[j] <= 16'hFFFF;
      for (int i = 0; i < BUF_WORDS; i++) begin
        b_addr[i] <= '0;
        b_data[i] <= '0;
      end
      lock <= '0; mode <= M_ARRAY; seq <= S_IDLE; s_blk <= '0;
      {err_e, err_p, err_v, err_l} <= '0;
      p_run <= 1'b0; p_susp <= 1'b0; p_req <= 1'b0; p_cnt <= '0;
      p_kind <= K_WORD; p_addr <= '0; p_data <= '0;
      e_run <= 1'b0; e_susp <= 1'b0; e_req <= 1'b0; e_cnt <= '0; e_blk <= '0;
      b_last <= '0; b_idx <= '0;
    end else begin
      if (p_done) begin
        p_run <= 1'b0;
        p_req <= 1'b0;
        case (p_kind)
          K_WORD: mem[p_addr] <= mem[p_addr] & p_data;
          K_BUF:
            for (int i = 0; i < BUF_WORDS; i++)
              if (BW'(i) <= b_last) mem[b_addr[i]] <= mem[b_addr[i]] & b_data[i];
          K_LSET: lock[p_addr[AW-1 -: BLK_W]] <= 1'b1;
          default: lock <= '0;
        endcase
      end else if (p_halt) begin
        p_susp <= 1'b1;
        p_req  <= 1'b0;
      end else if (p_act) p_cnt <= p_cnt - CW'(1);

      if (e_done) begin
        e_run <= 1'b0;
        e_req <= 1'b0;
        for (int j = 0; j < DEPTH; j++)
          if ((j >> OFF_W) == int'(e_blk)) mem[j] <= 16'hFFFF;
      end else if (e_halt) begin
        e_susp <= 1'b1;
        e_req  <= 1'b0;
      end else if (e_act) e_cnt <= e_cnt - CW'(1);

      if (wr_en) begin
        if (!ready) begin
          if (cmd == 8'h70) mode <= M_STATUS;
          else if (cmd == 8'hB0) begin
            mode <= M_STATUS;
            if (p_act && (p_kind == K_WORD || p_kind == K_BUF)) p_req <= 1'b1;
            else if (e_act) e_req <= 1'b1;
          end
        end else begin
          case (seq)
            S_IDLE: begin
              case (cmd)
                8'hFF: mode <= M_ARRAY;
                8'h70: mode <= M_STATUS;
                8'h90: mode <= M_IDENT;
                8'h98: mode <= M_QUERY;
                8'h50: {err_e, err_p, err_v, err_l} <= '0;
                8'h40, 8'h10: if (!p_run) begin seq <= S_PDATA; mode <= M_STATUS; end
                8'hE8: if (!p_run) begin seq <= S_BCNT; s_blk <= w_blk; mode <= M_STATUS; end
                8'h20: if (!p_run && !e_run) begin seq <= S_ECONF; s_blk <= w_blk; mode <= M_STATUS; end
                8'h60: if (!p_run && !e_run) begin seq <= S_LCONF; s_blk <= w_blk; mode <= M_STATUS; end
                8'hD0: begin
                  if (p_susp) begin
                    p_susp <= 1'b0; p_req <= 1'b0; mode <= M_STATUS;
                  end else if (e_susp && !p_run) begin
                    e_susp <= 1'b0; e_req <= 1'b0; mode <= M_STATUS;
                  end
                end
                default: ;
              endcase
            end
            S_PDATA: begin
              seq <= S_IDLE;
              if (!vpen_ok) {err_v, err_p} <= 2'b11;
              else if (lock[w_blk]) {err_l, err_p} <= 2'b11;
              else begin
                p_run <= 1'b1; p_req <= 1'b0; p_cnt <= CW'(PROG_CYC);
                p_kind <= K_WORD; p_addr <= wr_addr; p_data <= wr_data;
              end
            end
            S_ECONF: begin
              seq <= S_IDLE;
              if (cmd != 8'hD0) {err_e, err_p} <= 2'b11;
              else if (!vpen_ok) {err_v, err_p} <= 2'b11;
              else if (lock[s_blk]) {err_l, err_e} <= 2'b11;
              else begin
                e_run <= 1'b1; e_req <= 1'b0; e_cnt <= CW'(ERASE_CYC); e_blk <= s_blk;
              end
            end
            S_LCONF: begin
              seq <= S_IDLE;
              if (cmd != 8'h01 && cmd != 8'hD0) {err_e, err_p} <= 2'b11;
              else if (!vpen_ok) {err_v, err_p} <= 2'b11;
              else begin
                p_run <= 1'b1; p_req <= 1'b0; p_cnt <= CW'(PROG_CYC);
                p_kind <= (cmd == 8'h01) ? K_LSET : K_LCLR;
                p_addr <= {s_blk, {OFF_W{1'b0}}};
              end
            end
            S_BCNT: begin
              if (int'(wr_data) > BUF_WORDS - 1) begin
                {err_e, err_p} <= 2'b11;
                seq <= S_IDLE;
              end else begin
                b_last <= wr_data[BW-1:0];
                b_idx  <= '0;
                seq    <= S_BDATA;
              end
            end
            S_BDATA: begin
              b_addr[b_idx] <= wr_addr;
              b_data[b_idx] <= wr_data;
              b_idx <= b_idx + BW'(1);
              if (b_idx == b_last) seq <= S_BCONF;
            end
            default: begin
              seq <= S_IDLE;
              if (cmd != 8'hD0) {err_e, err_p} <= 2'b11;
              else if (!vpen_ok) {err_v, err_p} <= 2'b11;
              else if (lock[s_blk]) {err_l, err_p} <= 2'b11;
              else begin
                p_run <= 1'b1; p_req <= 1'b0; p_cnt <= CW'(PROG_CYC); p_kind <= K_BUF;
              end
            end
          endcase
        end
      end
    end
  end
endmodule

// File: rtl/nor_cmd_ctrl_chk.sv
module nor_cmd_ctrl_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        wr_en,
  input logic        rd_valid,
  input logic [15:0] rd_data,
  input logic        ready,
  input logic        vpen_ok,
  input logic [1:0]  mode,
  input logic        p_run,
  input logic        p_susp,
  input logic        e_run,
  input logic        e_susp
);
  assert_busy_quiet_R4: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid && $past(mode) == 2'd1 && !$past(ready) |-> rd_data == 16'h0000);

  assert_start_by_write_R12: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ready) |-> $past(wr_en));

  assert_prog_supply_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(p_run) |-> $past(vpen_ok));

  assert_erase_supply_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(e_run) |-> $past(vpen_ok));

  assert_erase_halt_ready_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(e_susp) |-> ready);

  assert_prog_halt_ready_R11: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(p_susp) |-> ready);

  assert_single_engine_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !(p_run && !p_susp && e_run && !e_susp));
endmodule

bind nor_cmd_ctrl nor_cmd_ctrl_chk i_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_valid(rd_valid), .rd_data(rd_data),
  .ready(ready), .vpen_ok(vpen_ok), .mode(mode), .p_run(p_run), .p_susp(p_susp),
  .e_run(e_run), .e_susp(e_susp)
);

// File: tb/test_nor_cmd_ctrl.sv
module test_nor_cmd_ctrl;
  localparam int PC = 6;
  localparam int EC = 12;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [7:0]  wr_addr = '0;
  logic [15:0] wr_data = '0;
  logic        rd_en = 1'b0;
  logic [7:0]  rd_addr = '0;
  logic        rd_valid;
  logic [15:0] rd_data;
  logic        vpen_ok = 1'b1;
  logic        ready;

  int checks = 0;
  int fails  = 0;
  logic [15:0] exp_q [$];
  string       tag_q [$];

  always #10 clk = ~clk;

  nor_cmd_ctrl i_nor_cmd_ctrl (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_en(rd_en), .rd_addr(rd_addr), .rd_valid(rd_valid), .rd_data(rd_data),
    .vpen_ok(vpen_ok), .ready(ready)
  );

  always @(negedge clk) begin
    if (rd_valid) begin
      checks++;
      if (exp_q.size() == 0) begin
        fails++;
        $display("FAIL unexpected read: actual %h expected none", rd_data);
      end else begin
        automatic logic [15:0] e = exp_q.pop_front();
        automatic string t = tag_q.pop_front();
        if (rd_data !== e) begin
          fails++;
          $display("FAIL %s: actual %h expected %h", t, rd_data, e);
        end
      end
    end
  end

  task automatic wr(input logic [7:0] a, input logic [15:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, input logic [15:0] e, input string t);
    exp_q.push_back(e); tag_q.push_back(t);
    rd_en = 1'b1; rd_addr = a;
    @(negedge clk);
    rd_en = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input logic act, input logic e, input string t);
    checks++;
    if (act !== e) begin
      fails++;
      $display("FAIL %s: actual %b expected %b", t, act, e);
    end
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    idle(3);
    rst_n = 1'b1;
    idle(1);
    // R1 reset state
    chk(ready, 1'b1, "R1 ready after reset");
    rd(8'h00, 16'hFFFF, "R1 erased word");
    wr(8'h00, 16'h0070);
    rd(8'h00, 16'h0080, "R1 R2 reset status");

    // R13 identifier and query
    wr(8'h00, 16'h0090);
    rd(8'h00, 16'h0089, "R13 manufacturer");
    rd(8'h01, 16'h0017, "R13 device code");
    rd(8'h02, 16'h0000, "R13 unlocked");
    wr(8'h00, 16'h0098);
    rd(8'h10, 16'h0051, "R13 query Q");
    rd(8'h11, 16'h0052, "R13 query R");
    rd(8'h12, 16'h0059, "R13 query Y");

    // R3 R4 program timing
    wr(8'h05, 16'h0040);
    wr(8'h05, 16'h1234);
    rd(8'h00, 16'h0000, "R4 busy status");
    idle(PC - 2);
    rd(8'h00, 16'h0000, "R3 still busy last cycle");
    rd(8'h00, 16'h0080, "R3 ready after program");
    chk(ready, 1'b1, "R3 ready port");
    wr(8'h00, 16'h00FF);
    rd(8'h05, 16'h1234, "R2 R3 programmed word");
    wr(8'h05, 16'h0010);
    wr(8'h05, 16'hFF0F);
    idle(PC + 2);
    wr(8'h00, 16'h00FF);
    rd(8'h05, 16'h1204, "R3 AND programming");

    // R12 command ignored while busy
    wr(8'h06, 16'h0040);
    wr(8'h06, 16'h00AA);
    wr(8'h00, 16'h00FF);
    rd(8'h06, 16'h0000, "R12 FF ignored while busy");
    idle(PC + 2);
    rd(8'h06, 16'h0080, "R12 ready again");

    // R7 R8 lock bits
    wr(8'h40, 16'h0060);
    wr(8'h40, 16'h0001);
    idle(PC + 2);
    wr(8'h00, 16'h0090);
    rd(8'h42, 16'h0001, "R7 R13 lock bit set");
    wr(8'h41, 16'h0040);
    wr(8'h41, 16'h0000);
    rd(8'h00, 16'h0092, "R7 program locked block");
    wr(8'h00, 16'h00FF);
    wr(8'h00, 16'h0070);
    rd(8'h00, 16'h0092, "R8 error bits sticky");
    wr(8'h40, 16'h0020);
    wr(8'h40, 16'h00D0);
    rd(8'h00, 16'h00B2, "R7 erase locked block");
    wr(8'h00, 16'h0050);
    rd(8'h00, 16'h0080, "R8 clear status");
    wr(8'h00, 16'h00FF);
    rd(8'h41, 16'hFFFF, "R7 locked word unchanged");
    wr(8'h00, 16'h0060);
    wr(8'h00, 16'h00D0);
    idle(PC + 2);
    wr(8'h00, 16'h0090);
    rd(8'h42, 16'h0000, "R7 lock bits cleared");

    // R6 supply lockout
    vpen_ok = 1'b0;
    wr(8'h07, 16'h0040);
    wr(8'h07, 16'h0000);
    rd(8'h00, 16'h0098, "R6 program lockout");
    chk(ready, 1'b1, "R6 never busy");
    wr(8'h00, 16'h0050);
    wr(8'h00, 16'h0020);
    wr(8'h00, 16'h00D0);
    rd(8'h00, 16'h0098, "R6 erase lockout");
    wr(8'h00, 16'h0050);
    vpen_ok = 1'b1;
    wr(8'h00, 16'h00FF);
    rd(8'h07, 16'hFFFF, "R6 word unchanged");
    rd(8'h05, 16'h1204, "R6 block not erased");

    // R5 bad erase confirm
    wr(8'h80, 16'h0020);
    wr(8'h80, 16'h00FF);
    rd(8'h00, 16'h00B0, "R5 bad sequence");
    wr(8'h00, 16'h0050);

    // R9 R10 erase suspend
    wr(8'h81, 16'h0040);
    wr(8'h81, 16'h5555);
    idle(PC + 2);
    wr(8'h80, 16'h0020);
    wr(8'h80, 16'h00D0);
    wr(8'h00, 16'h00B0);
    rd(8'h00, 16'h0000, "R9 busy after suspend request");
    idle(2);
    rd(8'h00, 16'h0000, "R9 busy before checkpoint");
    rd(8'h00, 16'h00C0, "R9 halted at checkpoint");
    wr(8'h00, 16'h00FF);
    rd(8'h81, 16'h5555, "R10 read during erase suspend");
    wr(8'h09, 16'h0040);
    wr(8'h09, 16'h0F0F);
    idle(PC + 2);
    rd(8'h00, 16'h00C0, "R10 program during erase suspend");
    wr(8'h00, 16'h0020);
    wr(8'h00, 16'h0070);
    rd(8'h00, 16'h00C0, "R12 erase ignored while suspended");
    wr(8'h00, 16'h00D0);
    idle(EC + 2);
    rd(8'h00, 16'h0080, "R9 resumed erase done");
    wr(8'h00, 16'h00FF);
    rd(8'h81, 16'hFFFF, "R5 R9 block erased");
    rd(8'h09, 16'h0F0F, "R10 nested program kept");

    // R11 program suspend
    wr(8'h0A, 16'h0040);
    wr(8'h0A, 16'h00F0);
    wr(8'h00, 16'h00B0);
    idle(4);
    rd(8'h00, 16'h0084, "R11 program suspended");
    wr(8'h00, 16'h00FF);
    rd(8'h0A, 16'hFFFF, "R11 word not yet written");
    wr(8'h00, 16'h00D0);
    idle(PC + 2);
    rd(8'h00, 16'h0080, "R11 resumed program done");
    wr(8'h00, 16'h00FF);
    rd(8'h0A, 16'h00F0, "R11 word programmed");

    // R14 buffered program
    wr(8'hC0, 16'h00E8);
    wr(8'hC0, 16'h0002);
    wr(8'hC1, 16'h1111);
    wr(8'hC2, 16'h2222);
    wr(8'hC3, 16'h3333);
    wr(8'hC0, 16'h00D0);
    rd(8'h00, 16'h0000, "R14 busy");
    idle(PC + 2);
    rd(8'h00, 16'h0080, "R14 ready");
    wr(8'h00, 16'h00FF);
    rd(8'hC1, 16'h1111, "R14 word 0");
    rd(8'hC2, 16'h2222, "R14 word 1");
    rd(8'hC3, 16'h3333, "R14 word 2");
    wr(8'hC0, 16'h00E8);
    wr(8'hC0, 16'h0005);
    rd(8'h00, 16'h00B0, "R14 count too large");
    wr(8'h00, 16'h0050);
    wr(8'hC4, 16'h00E8);
    wr(8'hC4, 16'h0000);
    wr(8'hC4, 16'h0000);
    wr(8'hC4, 16'h00FF);
    rd(8'h00, 16'h00B0, "R5 bad buffer confirm");
    wr(8'h00, 16'h00FF);
    rd(8'hC4, 16'hFFFF, "R5 buffer not programmed");

    idle(4);
    if (exp_q.size() != 0) begin
      fails++;
      $display("FAIL scoreboard: actual %0d pending expected 0", exp_q.size());
    end
    finish_run();
  end
endmodule